// File: doc/BRIEF.md
# Low-Power Autoreload Timer with Write Handshake

This block is an up-counting timer that runs from a slow kernel clock and is programmed from a fast bus clock. A power-of-two prescaler sets the rate at which the counter advances. When the count equals the programmed reload value, the next count returns it to zero and a sticky match flag is raised. Counting starts only when the enable bit is set and a start pulse is written. It then runs continuously until the enable is cleared.

Writes to the reload register and to the interrupt-enable register are carried into the kernel domain by a toggle handshake. Each finished transfer raises a ready flag in the bus domain. Software waits for that flag before writing the same register again. A write that arrives while the previous transfer is still in flight is dropped. The count is brought back to the bus through a per-bit two-flop synchroniser, so a single read can be torn. Software treats a value as valid only after two identical consecutive reads. The interrupt output is the OR of every active flag that has its enable set.

Top module: `lpt_timer`

## Requirements
- R1: After reset, status (byte offset 0x00) reads 0, the reload register (0x14) reads 0x0001, the count (0x18) reads 0, and irq is low.
- R2: Bits [2:0] of the config register (0x0C) hold n. While running, the counter advances once every 2^n kernel clock cycles, for n = 0 to 7.
- R3: With reload value A, the counter counts 0 to A and then returns to 0. The period is (A+1)·2^n kernel cycles, and each return to zero sets status bit 0 (match).
- R4: Status flags stay set until a one is written to the same bit position of the clear register (0x04). Writing a zero leaves a flag unchanged. Bit 0 is match, bit 1 is reload-ready and bit 2 is enable-ready.
- R5: A write to the reload register (0x14) sets status bit 1 once the handshake has completed. The new value governs the wrap point at once, with no wait for the current period to end.
- R6: A reload or interrupt-enable write issued while that register's previous transfer is still pending is dropped, and the register keeps the first value.
- R7: Interrupt-enable bits at 0x08 (bit 0 match, bit 1 reload-ready, bit 2 enable-ready) take effect only when the transfer completes. Completion sets status bit 2.
- R8: irq is high exactly one bus cycle after some status flag and its effective enable bit are both set. irq is low when no enabled flag is active.
- R9: Control register 0x10 has bit 0 as enable and bit 1 as a write-only start pulse. While enabled but not started, the count stays 0. Clearing enable forces the count to 0, and no further match occurs.
- R10: If the reload is set below the current count, the counter keeps counting to its all-ones value, wraps to 0 without a match, and then uses the new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| kclk | input | 1 | Slow kernel clock for prescaler and counter |
| rst | input | 1 | Synchronous active-high reset, seen in both domains |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Word-aligned byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, decoded from bus_addr |
| irq | output | 1 | OR of enabled, active flags |

## Verification
A wrong prescaler or reload state shows up directly as a wrong interval between match flags. The bench measures that interval in kernel cycles within one or two periods of starting. A broken handshake shows as a ready flag that never rises or rises too early, or as a reload value that a second write overwrites. Both appear within a few kernel cycles of the write. A wrong enable path shows on irq two bus cycles after the enable transfer completes or after a flag is cleared. A counter that fails to overflow past a lowered reload raises a match flag too early, and that is caught thousands of cycles before the correct wrap.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 32;
    localparam int PSC_W     = 3;
    localparam int PSC_CNT_W = (1 << PSC_W) - 1;
    localparam int FLAG_N    = 3;

    localparam logic [ADDR_W-1:0] A_STATUS = 5'h00;
    localparam logic [ADDR_W-1:0] A_CLEAR  = 5'h04;
    localparam logic [ADDR_W-1:0] A_IEN    = 5'h08;
    localparam logic [ADDR_W-1:0] A_CFG    = 5'h0C;
    localparam logic [ADDR_W-1:0] A_CTRL   = 5'h10;
    localparam logic [ADDR_W-1:0] A_RELOAD = 5'h14;
    localparam logic [ADDR_W-1:0] A_COUNT  = 5'h18;

    // bit positions shared by status, clear and interrupt-enable
    typedef struct packed {
        logic ien_ok;
        logic rld_ok;
        logic match;
    } flags_t;

    // low bits that must all be one for a prescaler tick at ratio 2^n
    function automatic logic [PSC_CNT_W-1:0] psc_mask(input logic [PSC_W-1:0] n);
        return PSC_CNT_W'((32'd1 << n) - 32'd1);
    endfunction
endpackage

// File: rtl/lpt_sync2.sv
module lpt_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/lpt_wsync.sv
// Carries one register value from the bus domain into the kernel domain
// with a toggle request and a returned toggle acknowledge.
module lpt_wsync #(
    parameter int         W       = 16,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         kclk,
    input  logic         rst,
    input  logic         launch,
    input  logic [W-1:0] din,
    output logic [W-1:0] hold,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] kq
);
    logic req_t, req_k, ack_t, ack_b, ack_b_d;

    assign busy = (req_t != ack_b);
    assign done = (ack_b != ack_b_d);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold    <= RST_VAL;
            req_t   <= 1'b0;
            ack_b_d <= 1'b0;
        end else begin
            ack_b_d <= ack_b;
            if (launch && !busy) begin
                hold  <= din;
                req_t <= ~req_t;
            end
        end
    end

    lpt_sync2 #(.W(1)) u_req (.clk(kclk), .rst(rst), .d(req_t), .q(req_k));

    // hold is stable while the request is outstanding
    always_ff @(posedge kclk) begin
        if (rst) begin
            ack_t <= 1'b0;
            kq    <= RST_VAL;
        end else if (req_k != ack_t) begin
            ack_t <= req_k;
            kq    <= hold;
        end
    end

    lpt_sync2 #(.W(1)) u_ack (.clk(clk), .rst(rst), .d(ack_t), .q(ack_b));
endmodule

// File: rtl/lpt_core.sv
module lpt_core
    import lpt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             kclk,
    input  logic             rst,
    input  logic             en,
    input  logic [PSC_W-1:0] psc,
    input  logic             start_lvl,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt,
    output logic             match_t
);
    logic                 running;
    logic                 start_d;
    logic                 start_p;
    logic                 tick;
    logic [PSC_CNT_W-1:0] pc;
    logic [PSC_CNT_W-1:0] mask;

    assign mask    = psc_mask(psc);
    assign start_p = (start_lvl != start_d);
    assign tick    = running && ((pc & mask) == mask);

    always_ff @(posedge kclk) begin
        if (rst) start_d <= 1'b0;
        else     start_d <= start_lvl;
    end

    always_ff @(posedge kclk) begin
        if (rst || !en) begin
            running <= 1'b0;
            pc      <= '0;
            cnt     <= '0;
        end else begin
            if (start_p) running <= 1'b1;
            if (running) pc <= tick ? '0 : pc + 1'b1;
            // a count above reload runs on and wraps naturally at all-ones
            if (tick) cnt <= (cnt == reload) ? '0 : cnt + 1'b1;
        end
    end

    always_ff @(posedge kclk) begin
        if (rst)                          match_t <= 1'b0;
        else if (en && tick && cnt == reload) match_t <= ~match_t;
    end
endmodule

// File: rtl/lpt_timer.sv
module lpt_timer
    import lpt_pkg::*;
#(
    parameter int               CNT_W      = 16,
    parameter logic [CNT_W-1:0] RELOAD_RST = 1
) (
    input  logic              clk,
    input  logic              kclk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic              wr_en;
    logic              rld_launch, ien_launch;
    logic [CNT_W-1:0]  rld_hold, reload_k;
    logic              rld_busy, rld_done;
    logic [FLAG_N-1:0] ien_hold, ien_k, ien_eff;
    logic              ien_busy, ien_done;
    logic              en_q, start_t;
    logic [PSC_W-1:0]  psc_q, psc_k;
    logic              en_k, start_k;
    logic [CNT_W-1:0]  cnt_k, cnt_b;
    logic              match_t, match_s, match_d, match_evt;
    logic [FLAG_N-1:0] flags_q, clr_vec, set_vec;
    flags_t            set_s;
    logic              unused_wdata;

    assign unused_wdata = ^bus_wdata;
    assign wr_en        = bus_sel && bus_wr;
    assign rld_launch   = wr_en && (bus_addr == A_RELOAD);
    assign ien_launch   = wr_en && (bus_addr == A_IEN);

    // ---------------- bus-side control registers ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= 1'b0;
            psc_q   <= '0;
            start_t <= 1'b0;
        end else begin
            if (wr_en && bus_addr == A_CFG) psc_q <= bus_wdata[PSC_W-1:0];
            if (wr_en && bus_addr == A_CTRL) begin
                en_q <= bus_wdata[0];
                if (bus_wdata[1]) start_t <= ~start_t;
            end
        end
    end

    // ---------------- handshaken registers ----------------
    lpt_wsync #(.W(CNT_W), .RST_VAL(RELOAD_RST)) u_rld (
        .clk(clk), .kclk(kclk), .rst(rst),
        .launch(rld_launch), .din(bus_wdata[CNT_W-1:0]),
        .hold(rld_hold), .busy(rld_busy), .done(rld_done), .kq(reload_k)
    );

    lpt_wsync #(.W(FLAG_N), .RST_VAL('0)) u_ien (
        .clk(clk), .kclk(kclk), .rst(rst),
        .launch(ien_launch), .din(bus_wdata[FLAG_N-1:0]),
        .hold(ien_hold), .busy(ien_busy), .done(ien_done), .kq(ien_k)
    );

    // enable copy returns with the same latency as the acknowledge
    lpt_sync2 #(.W(FLAG_N)) u_ien_back (.clk(clk), .rst(rst), .d(ien_k), .q(ien_eff));

    // ---------------- level and toggle crossings into kernel ----------------
    lpt_sync2 #(.W(1 + PSC_W)) u_cfg_k (
        .clk(kclk), .rst(rst), .d({en_q, psc_q}), .q({en_k, psc_k})
    );
    lpt_sync2 #(.W(1)) u_start_k (.clk(kclk), .rst(rst), .d(start_t), .q(start_k));

    lpt_core #(.CNT_W(CNT_W)) u_core (
        .kclk(kclk), .rst(rst), .en(en_k), .psc(psc_k), .start_lvl(start_k),
        .reload(reload_k), .cnt(cnt_k), .match_t(match_t)
    );

    // ---------------- crossings back into bus ----------------
    lpt_sync2 #(.W(1))     u_match_b (.clk(clk), .rst(rst), .d(match_t), .q(match_s));
    lpt_sync2 #(.W(CNT_W)) u_cnt_b   (.clk(clk), .rst(rst), .d(cnt_k),   .q(cnt_b));

    always_ff @(posedge clk) begin
        if (rst) match_d <= 1'b0;
        else     match_d <= match_s;
    end
    assign match_evt = (match_s != match_d);

    // ---------------- status flags and interrupt ----------------
    assign set_s   = '{ien_ok: ien_done, rld_ok: rld_done, match: match_evt};
    assign set_vec = set_s;
    assign clr_vec = (wr_en && bus_addr == A_CLEAR) ? bus_wdata[FLAG_N-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            irq     <= 1'b0;
        end else begin
            flags_q <= (flags_q & ~clr_vec) | set_vec;
            irq     <= |(flags_q & ien_eff);
        end
    end

    // ---------------- read decode ----------------
    always_comb begin
        case (bus_addr)
            A_STATUS: bus_rdata = DATA_W'(flags_q);
            A_IEN:    bus_rdata = DATA_W'(ien_hold);
            A_CFG:    bus_rdata = DATA_W'(psc_q);
            A_CTRL:   bus_rdata = DATA_W'(en_q);
            A_RELOAD: bus_rdata = DATA_W'(rld_hold);
            A_COUNT:  bus_rdata = DATA_W'(cnt_b);
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/lpt_timer_chk.sv
module lpt_timer_chk
    import lpt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic              clk,
    input logic              kclk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [FLAG_N-1:0] flags_q,
    input logic [FLAG_N-1:0] ien_eff,
    input logic              irq,
    input logic              rld_busy,
    input logic [CNT_W-1:0]  rld_hold,
    input logic              ien_busy,
    input logic [FLAG_N-1:0] ien_hold,
    input logic              en_k,
    input logic [CNT_W-1:0]  cnt_k
);
    logic clr_wr;
    assign clr_wr = bus_sel && bus_wr && (bus_addr == A_CLEAR);

    p_irq_source_r8: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(|(flags_q & ien_eff)));

    p_irq_raise_r8: assert property (@(posedge clk) disable iff (rst)
        (|(flags_q & ien_eff)) |=> irq);

    p_match_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (flags_q[0] && !(clr_wr && bus_wdata[0])) |=> flags_q[0]);

    p_rld_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (flags_q[1] && !(clr_wr && bus_wdata[1])) |=> flags_q[1]);

    p_rld_drop_r6: assert property (@(posedge clk) disable iff (rst)
        rld_busy |=> $stable(rld_hold));

    p_ien_drop_r6: assert property (@(posedge clk) disable iff (rst)
        ien_busy |=> $stable(ien_hold));

    p_hold_disabled_r9: assert property (@(posedge kclk) disable iff (rst)
        !en_k |=> (cnt_k == '0));

    p_count_step_r3: assert property (@(posedge kclk) disable iff (rst)
        en_k |=> (cnt_k == $past(cnt_k) || cnt_k == $past(cnt_k) + 1'b1 || cnt_k == '0));
endmodule

bind lpt_timer lpt_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .kclk(kclk), .rst(rst),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .flags_q(flags_q), .ien_eff(ien_eff), .irq(irq),
    .rld_busy(rld_busy), .rld_hold(rld_hold),
    .ien_busy(ien_busy), .ien_hold(ien_hold),
    .en_k(en_k), .cnt_k(cnt_k)
);

// File: tb/tb_lpt_timer.sv
module tb_lpt_timer;
    import lpt_pkg::*;

    localparam int CLK_PERIOD  = 10;
    localparam int KCLK_PERIOD = 2 * CLK_PERIOD;
    localparam int CNT_W       = 12;
    localparam int NVEC        = 5;
    // {n, reload, expected period in kernel cycles}
    localparam int VEC [NVEC][3] = '{'{0, 3, 4}, '{1, 5, 12}, '{3, 2, 24},
                                     '{2, 9, 40}, '{7, 1, 256}};

    logic              clk = 1'b0, kclk = 1'b0, rst = 1'b1;
    logic              bus_sel = 1'b0, bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              irq;

    int          n_run = 0, n_fail = 0;
    int unsigned kcount = 0;
    logic        finished = 1'b0;

    always #(CLK_PERIOD/2)  clk  = ~clk;
    always #(KCLK_PERIOD/2) kclk = ~kclk;
    always @(posedge kclk) kcount <= kcount + 1;

    lpt_timer #(.CNT_W(CNT_W)) dut (
        .clk(clk), .kclk(kclk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic check_near(input string tag, input int act, input int exp, input int tol);
        n_run++;
        if (act < exp - tol || act > exp + tol) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic read_count(output logic [31:0] v);
        logic [31:0] a, b;
        bus_read(A_COUNT, a);
        for (int i = 0; i < 20; i++) begin
            bus_read(A_COUNT, b);
            if (a == b) break;
            a = b;
        end
        v = b;
    endtask

    task automatic wait_flag(input int bitn, input int limit, output logic seen, output int unsigned at);
        logic [31:0] d;
        seen = 1'b0; at = 0;
        for (int i = 0; i < limit && !seen; i++) begin
            bus_read(A_STATUS, d);
            if (d[bitn]) begin seen = 1'b1; at = kcount; end
        end
    endtask

    task automatic measure_period(output int p);
        logic seen; int unsigned t0, t1;
        bus_write(A_CLEAR, 32'h1);
        wait_flag(0, 2000, seen, t0);
        bus_write(A_CLEAR, 32'h1);
        wait_flag(0, 2000, seen, t1);
        bus_write(A_CLEAR, 32'h1);
        p = seen ? int'(t1 - t0) : -1;
    endtask

    initial begin
        logic [31:0] d, c;
        logic seen;
        int unsigned at;
        int p;

        repeat (10) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R1 reset state
        bus_read(A_STATUS, d); check("R1 status", d, 32'h0);
        bus_read(A_RELOAD, d); check("R1 reload", d, 32'h1);
        bus_read(A_COUNT, d);  check("R1 count", d, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R2/R3 table of prescaler and reload settings
        for (int i = 0; i < NVEC; i++) begin
            bus_write(A_CTRL, 32'h0);
            repeat (8) @(negedge kclk);
            bus_write(A_CFG, VEC[i][0]);
            bus_write(A_RELOAD, VEC[i][1]);
            wait_flag(1, 200, seen, at);
            bus_write(A_CLEAR, 32'h2);
            bus_write(A_CTRL, 32'h1);
            repeat (6) @(negedge kclk);
            bus_write(A_CTRL, 32'h3);
            measure_period(p);
            check_near($sformatf("R2 R3 period n=%0d reload=%0d", VEC[i][0], VEC[i][1]),
                       p, VEC[i][2], 1);
        end

        // R9 enable without start, then start, then disable
        bus_write(A_CTRL, 32'h0);
        bus_write(A_CFG, 32'h0);
        bus_write(A_RELOAD, 32'h30);
        wait_flag(1, 200, seen, at);
        bus_write(A_CLEAR, 32'h7);
        bus_write(A_CTRL, 32'h1);
        repeat (40) @(negedge kclk);
        read_count(c); check("R9 held before start", c, 32'h0);
        bus_write(A_CTRL, 32'h3);
        repeat (20) @(negedge kclk);
        read_count(c); check("R9 counting after start", {31'b0, c != 0}, 32'h1);
        bus_write(A_CTRL, 32'h0);
        repeat (10) @(negedge kclk);
        bus_write(A_CLEAR, 32'h7);
        repeat (80) @(negedge kclk);
        read_count(c); check("R9 count zero when disabled", c, 32'h0);
        bus_read(A_STATUS, d); check("R9 no match when disabled", d & 32'h1, 32'h0);
        bus_write(A_CTRL, 32'h2);
        repeat (40) @(negedge kclk);
        read_count(c); check("R9 start ignored while disabled", c, 32'h0);

        // R6/R5 back-to-back reload writes
        bus_write(A_RELOAD, 32'h123);
        bus_write(A_RELOAD, 32'h45);
        bus_read(A_RELOAD, d); check("R6 second write dropped", d, 32'h123);
        wait_flag(1, 200, seen, at);
        check("R5 reload ready set", {31'b0, seen}, 32'h1);
        bus_read(A_STATUS, d); check("R5 only reload-ready set", d, 32'h2);

        // R7/R8 enable transfer and interrupt
        bus_write(A_IEN, 32'h2);
        check("R7 enable not yet in effect", {31'b0, irq}, 32'h0);
        wait_flag(2, 200, seen, at);
        check("R7 enable ready set", {31'b0, seen}, 32'h1);
        repeat (2) @(negedge clk);
        check("R8 irq from reload-ready", {31'b0, irq}, 32'h1);
        bus_write(A_CLEAR, 32'h0);
        bus_read(A_STATUS, d); check("R4 zero write keeps flags", d, 32'h6);
        bus_write(A_CLEAR, 32'h2);
        repeat (2) @(negedge clk);
        check("R8 irq drops after clear", {31'b0, irq}, 32'h0);
        bus_write(A_CLEAR, 32'h4);
        bus_read(A_STATUS, d); check("R4 one write clears", d, 32'h0);

        // R10 reload lowered below the running count
        bus_write(A_RELOAD, 32'h800);
        wait_flag(1, 200, seen, at);
        bus_write(A_CLEAR, 32'h2);
        bus_write(A_CTRL, 32'h1);
        repeat (6) @(negedge kclk);
        bus_write(A_CTRL, 32'h3);
        c = 0;
        for (int i = 0; i < 2000 && c < 32'h100; i++) read_count(c);
        bus_write(A_RELOAD, 32'h10);
        wait_flag(1, 200, seen, at);
        bus_write(A_CLEAR, 32'h3);
        read_count(c);
        check("R10 count above new reload", {31'b0, c > 32'h10}, 32'h1);
        repeat (1500) @(negedge kclk);
        bus_read(A_STATUS, d); check("R10 no early match", d & 32'h1, 32'h0);
        read_count(d); check("R10 count kept rising", {31'b0, d > c}, 32'h1);
        wait_flag(0, 8000, seen, at);
        check("R10 wrap reached", {31'b0, seen}, 32'h1);
        measure_period(p);
        check_near("R10 new period", p, 17, 1);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule